// File: doc/BRIEF.md
# Dual Delay-Line Random Bit Combiner

This block is the digital half of a two-channel random bit source built around delayed feedback. Each channel receives one asynchronous bit from an external window comparator. The comparator drives this bit high when the analog state is outside a band around zero and low when it is inside the band. The block brings each bit into the clock domain through two flops and passes it through a one-bit delay line held in RAM. The number of stages in the line can be programmed. The delayed bit is returned as the feedback drive for that channel's analog loop. The two analog halves run with no synchronization between them.

The XOR of the two feedback bits is sampled at a slower capture period, which is programmable. The captured bits are packed into bytes, most significant bit first. The bytes are queued in a small record FIFO and leave the block on a ready/valid port. When the FIFO is full, a completed byte is dropped and a sticky overflow flag is raised.

At a 20 ns clock, the nominal settings are a delay of 25000 stages (500 µs) and a capture period of 1000 clocks. Reaching a 25000-stage delay requires the address width parameter to be raised to 15.

Top module: `delay_xor_recorder`

## Requirements
- R1: While rstN is low, fbOut is 0, byteValid is low and overflow is low.
- R2: For a channel whose length N is 1 or more, fbOut after clock edge c equals the comparator value sampled at edge c-N-2. Two of those cycles are the synchronizer and N cycles are the delay line.
- R3: A programmed length of 0 behaves exactly like a length of 1.
- R4: Let r be the first edge after reset release, or the first edge that sees a new length on a channel. That channel's fbOut is 0 after every edge from r through r+N.
- R5: The two channels are independent: changing one channel's length does not disturb the feedback stream of the other channel.
- R6: Let P be capDiv, with 0 taken as 1. At edge j, counted from 1 after reset release, the value fbOut[0] XOR fbOut[1] present before the edge is captured whenever j mod P equals 0.
- R7: Eight successive captured bits form one byte. The first captured bit lands in bit 7 and the last in bit 0. The byte enters the FIFO at the edge of its eighth capture.
- R8: byteValid is high exactly when the FIFO holds at least one byte. Bytes leave oldest first, one per edge on which byteValid and byteReady are both high. While byteReady is low, byteValid and byteData hold their values.
- R9: A byte completed while the FIFO holds 2^FIFO_W bytes is dropped, and overflow goes high and stays high until reset. The bytes already stored are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpIn | input | 2 | Asynchronous comparator bits, one per channel |
| delayLenA | input | ADDR_W | Stage count N of channel 0 (0 acts as 1) |
| delayLenB | input | ADDR_W | Stage count N of channel 1 (0 acts as 1) |
| capDiv | input | CAP_W | Capture period in clocks (0 acts as 1) |
| fbOut | output | 2 | Delayed feedback bits, one per channel |
| byteData | output | 8 | Oldest packed byte in the record FIFO |
| byteValid | output | 1 | FIFO holds a byte |
| byteReady | input | 1 | Consumer accepts the presented byte |
| overflow | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |

## Verification
The delay lines are driven with three comparator patterns.
- A pseudo-random sequence on both channels exposes any off-by-one in latency or pointer wrap, because every cycle's bit is distinct.
- Two channels toggling in opposite phase give a constant XOR. A wrong pairing of the channels at the combiner therefore shows up directly in the captured bytes.
- One channel held high while the other is random shows whether the constant channel's delay is masked correctly after a length change.

The lengths are switched mid-run to 0, to small values and to values near the line size, with different values per channel, to exercise the quiet window and channel independence. A second run uses a capture period of 0 with the consumer stalled. This fills the FIFO, forces dropped bytes and checks that the stored bytes still drain in order.

// File: rtl/drbc_pkg.sv
package drbc_pkg;
  // number of delay-line channels combined by XOR
  localparam int NUM_CH = 2;
  // width of a packed output byte
  localparam int BYTE_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] restart;  // pointer restart this cycle (no write)
    logic [NUM_CH-1:0] wrEn;     // write the synchronized bit at the pointer
    logic [NUM_CH-1:0] primed;   // line fully refilled since last restart
    logic              capTick;  // capture the XOR bit this cycle
    logic              byteDone; // eighth capture: push the packed byte
  } strobes_t;
endpackage

// File: rtl/drbc_ctrl.sv
module drbc_ctrl
  import drbc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CAP_W  = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  chanLen,
  input  logic [CAP_W-1:0]               capDiv,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  rdPtr,
  output strobes_t                       stb
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [ADDR_W-1:0]    ONE_A    = ADDR_W'(1);
  localparam logic [CAP_W-1:0]     ONE_C    = CAP_W'(1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic              runQ;
  logic [NUM_CH-1:0] restartV;
  logic [NUM_CH-1:0] primedV;

  // first cycle after reset release is a restart for every channel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [ADDR_W-1:0] lenQ;
    logic [ADDR_W-1:0] ptrQ;
    logic [ADDR_W-1:0] effLen;
    logic              primedQ;

    assign effLen       = (chanLen[ch] == '0) ? ONE_A : chanLen[ch];
    assign restartV[ch] = !runQ || (chanLen[ch] != lenQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenQ    <= '0;
        ptrQ    <= '0;
        primedQ <= 1'b0;
      end else begin
        lenQ <= chanLen[ch];
        if (restartV[ch]) begin
          ptrQ    <= '0;
          primedQ <= 1'b0;
        end else if (ptrQ >= effLen - ONE_A) begin
          ptrQ    <= '0;
          primedQ <= 1'b1;
        end else begin
          ptrQ <= ptrQ + ONE_A;
        end
      end
    end

    assign rdPtr[ch]   = ptrQ;
    assign primedV[ch] = primedQ;
  end

  // capture divider and bit-in-byte counter
  logic [CAP_W-1:0]     capCntQ;
  logic [CAP_W-1:0]     effDiv;
  logic [BIT_CNT_W-1:0] bitCntQ;
  logic                 capTick;

  assign effDiv  = (capDiv == '0) ? ONE_C : capDiv;
  assign capTick = (capCntQ >= effDiv - ONE_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCntQ <= '0;
      bitCntQ <= '0;
    end else if (capTick) begin
      capCntQ <= '0;
      bitCntQ <= bitCntQ + BIT_CNT_W'(1);
    end else begin
      capCntQ <= capCntQ + ONE_C;
    end
  end

  assign stb = '{restart:  restartV,
                 wrEn:     ~restartV,
                 primed:   primedV,
                 capTick:  capTick,
                 byteDone: capTick && (bitCntQ == LAST_BIT)};
endmodule

// File: rtl/drbc_datapath.sv
module drbc_datapath
  import drbc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             cmpIn,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] rdPtr,
  input  strobes_t                      stb,
  output logic [NUM_CH-1:0]             fbOut,
  output logic [BYTE_W-1:0]             packedByte
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_line
    logic [1:0] syncQ;
    logic       validQ;
    logic       rdQ;
    logic       lineQ [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '0;
        validQ <= 1'b0;
      end else begin
        syncQ  <= {syncQ[0], cmpIn[ch]};
        validQ <= stb.primed[ch] && !stb.restart[ch];
      end
    end

    // read-first single-port RAM: old content leaves, new sample enters
    always_ff @(posedge clk) begin
      if (stb.wrEn[ch]) lineQ[rdPtr[ch]] <= syncQ[1];
      rdQ <= lineQ[rdPtr[ch]];
    end

    // entries not yet rewritten since restart are masked to zero
    assign fbOut[ch] = rdQ & validQ;
  end

  logic              xorBit;
  logic [BYTE_W-1:0] shQ;

  assign xorBit = ^fbOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shQ <= '0;
    else if (stb.capTick) shQ <= {shQ[BYTE_W-2:0], xorBit};
  end

  assign packedByte = {shQ[BYTE_W-2:0], xorBit};
endmodule

// File: rtl/drbc_recfifo.sv
module drbc_recfifo #(
  parameter int FIFO_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              ovfFlag
);
  localparam int DEPTH = 1 << FIFO_W;
  localparam logic [FIFO_W:0] FULL_CNT = (FIFO_W + 1)'(DEPTH);

  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [FIFO_W-1:0] wrPtrQ;
  logic [FIFO_W-1:0] rdPtrQ;
  logic [FIFO_W:0]   cntQ;
  logic              ovfQ;
  logic              full;
  logic              doPush;
  logic              doPop;

  assign full   = (cntQ == FULL_CNT);
  assign doPush = pushEn && !full;
  assign doPop  = popReady && (cntQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      cntQ   <= '0;
      ovfQ   <= 1'b0;
    end else begin
      if (doPush) wrPtrQ <= wrPtrQ + FIFO_W'(1);
      if (doPop)  rdPtrQ <= rdPtrQ + FIFO_W'(1);
      case ({doPush, doPop})
        2'b10:   cntQ <= cntQ + (FIFO_W + 1)'(1);
        2'b01:   cntQ <= cntQ - (FIFO_W + 1)'(1);
        default: cntQ <= cntQ;
      endcase
      if (pushEn && full) ovfQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slotQ[wrPtrQ] <= pushData;
  end

  assign outData  = slotQ[rdPtrQ];
  assign outValid = (cntQ != '0);
  assign ovfFlag  = ovfQ;
endmodule

// File: rtl/delay_xor_recorder.sv
module delay_xor_recorder
  import drbc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CAP_W  = 16,
  parameter int FIFO_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmpIn,
  input  logic [ADDR_W-1:0] delayLenA,
  input  logic [ADDR_W-1:0] delayLenB,
  input  logic [CAP_W-1:0]  capDiv,
  output logic [1:0]        fbOut,
  output logic [7:0]        byteData,
  output logic              byteValid,
  input  logic              byteReady,
  output logic              overflow
);
  logic [NUM_CH-1:0][ADDR_W-1:0] chanLen;
  logic [NUM_CH-1:0][ADDR_W-1:0] rdPtr;
  logic [BYTE_W-1:0]             packedByte;
  strobes_t                      stb;

  assign chanLen[0] = delayLenA;
  assign chanLen[1] = delayLenB;

  drbc_ctrl #(.ADDR_W(ADDR_W), .CAP_W(CAP_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .chanLen (chanLen),
    .capDiv  (capDiv),
    .rdPtr   (rdPtr),
    .stb     (stb)
  );

  drbc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmpIn      (cmpIn),
    .rdPtr      (rdPtr),
    .stb        (stb),
    .fbOut      (fbOut),
    .packedByte (packedByte)
  );

  drbc_recfifo #(.FIFO_W(FIFO_W), .DATA_W(BYTE_W)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (stb.byteDone),
    .pushData (packedByte),
    .popReady (byteReady),
    .outData  (byteData),
    .outValid (byteValid),
    .ovfFlag  (overflow)
  );
endmodule

// File: rtl/drbc_checker.sv
module drbc_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] delayLenA,
  input logic [ADDR_W-1:0] delayLenB,
  input logic [1:0]        fbOut,
  input logic [7:0]        byteData,
  input logic              byteValid,
  input logic              byteReady,
  input logic              overflow
);
  // R1: outputs quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (fbOut == 2'b00 && !byteValid && !overflow));

  // R4: a length change silences that channel's feedback on the next cycle
  assert_quiet_after_len_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    (delayLenA != $past(delayLenA)) |=> !fbOut[0]);

  assert_quiet_after_len_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    (delayLenB != $past(delayLenB)) |=> !fbOut[1]);

  // R8: a stalled byte is held unchanged
  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady) |=> (byteValid && $stable(byteData)));

  // R9: overflow is sticky
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9: overflow only rises when the FIFO already held data
  assert_overflow_needs_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(byteValid));
endmodule

bind delay_xor_recorder drbc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/delay_xor_recorder_tb.sv
module delay_xor_recorder_tb;
  localparam int AW     = 6;
  localparam int CW     = 8;
  localparam int FW     = 2;
  localparam int FDEPTH = 1 << FW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    cmpIn;
  logic [AW-1:0] delayLenA;
  logic [AW-1:0] delayLenB;
  logic [CW-1:0] capDiv;
  logic [1:0]    fbOut;
  logic [7:0]    byteData;
  logic          byteValid;
  logic          byteReady;
  logic          overflow;

  always #5 clk = ~clk;

  delay_xor_recorder #(.ADDR_W(AW), .CAP_W(CW), .FIFO_W(FW)) u_dut (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .delayLenA(delayLenA),
    .delayLenB(delayLenB), .capDiv(capDiv), .fbOut(fbOut),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .overflow(overflow)
  );

  int checks = 0;
  int fails  = 0;
  int cyc;
  int rA, rB;
  int mode;
  bit histA [4096];
  bit histB [4096];
  bit prevA, prevB;
  bit [7:0] packSh;
  int packCnt;
  bit ovfModel;
  bit popPending;
  bit [7:0] expQ [$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int effOf(input logic [AW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic bit expA(input int c);
    int n = effOf(delayLenA);
    if (c - rA > n) return histA[c - n - 2];
    return 1'b0;
  endfunction

  function automatic bit expB(input int c);
    int n = effOf(delayLenB);
    if (c - rB > n) return histB[c - n - 2];
    return 1'b0;
  endfunction

  function automatic string tagFor(input int c, input int r, input logic [AW-1:0] len);
    if (len == 0) return "R3";
    if (c - r <= effOf(len)) return "R4";
    return "R2";
  endfunction

  task automatic driveNext();
    bit a, b;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0:       begin a = lfsr[0]; b = lfsr[7]; end
      1:       begin a = cyc[0];  b = ~cyc[0]; end
      default: begin a = 1'b1;    b = lfsr[3]; end
    endcase
    cmpIn = {b, a};
    histA[cyc + 1] = a;
    histB[cyc + 1] = b;
  endtask

  task automatic step();
    bit ea, eb;
    int divEff;
    string tb;
    popPending = (expQ.size() > 0) && byteReady;
    divEff = (capDiv == 0) ? 1 : int'(capDiv);
    @(posedge clk);
    cyc++;
    // R6: capture model
    if (cyc % divEff == 0) begin
      packSh = {packSh[6:0], prevA ^ prevB};
      packCnt++;
      if (packCnt == 8) begin
        packCnt = 0;
        if (expQ.size() < FDEPTH) expQ.push_back(packSh);
        else ovfModel = 1'b1;
      end
    end
    if (popPending) void'(expQ.pop_front());
    @(negedge clk);
    ea = expA(cyc);
    eb = expB(cyc);
    check(fbOut[0] == ea, tagFor(cyc, rA, delayLenA), "fbOut[0]", fbOut[0], ea);
    tb = (rA > 1 && cyc - rA < 40) ? "R5" : tagFor(cyc, rB, delayLenB);
    check(fbOut[1] == eb, tb, "fbOut[1]", fbOut[1], eb);
    check(byteValid == (expQ.size() > 0), "R8", "byteValid", byteValid, expQ.size() > 0);
    if (expQ.size() > 0)
      check(byteData == expQ[0], "R6,R7", "byteData", byteData, expQ[0]);
    check(overflow == ovfModel, "R9", "overflow", overflow, ovfModel);
    prevA = ea;
    prevB = eb;
    driveNext();
  endtask

  task automatic runSteps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doReset(input int div, input int la, input int lb, input bit rdy);
    @(negedge clk);
    rstN      = 1'b0;
    cmpIn     = 2'b00;
    capDiv    = CW'(div);
    delayLenA = AW'(la);
    delayLenB = AW'(lb);
    byteReady = rdy;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(fbOut == 2'b00, "R1", "fbOut in reset", fbOut, 0);
    check(!byteValid, "R1", "byteValid in reset", byteValid, 0);
    check(!overflow, "R1", "overflow in reset", overflow, 0);
    rstN     = 1'b1;
    cyc      = 0;
    rA       = 1;
    rB       = 1;
    histA[0] = 1'b0;
    histB[0] = 1'b0;
    histA[1] = cmpIn[0];
    histB[1] = cmpIn[1];
    prevA    = 1'b0;
    prevB    = 1'b0;
    packSh   = '0;
    packCnt  = 0;
    ovfModel = 1'b0;
    expQ.delete();
  endtask

  task automatic setLenA(input int v);
    delayLenA = AW'(v);
    rA = cyc + 1;
  endtask

  task automatic setLenB(input int v);
    delayLenB = AW'(v);
    rB = cyc + 1;
  endtask

  initial begin
    rstN = 1'b0;
    cmpIn = 2'b00;
    byteReady = 1'b1;
    mode = 0;
    // run 1: pseudo-random inputs, distinct lengths (R2, R4, R6, R7, R8)
    doReset(3, 5, 9, 1'b1);
    runSteps(300);
    // zero length acts as one (R3); anti-phase toggles; B must be undisturbed (R5)
    mode = 1;
    setLenA(0);
    runSteps(120);
    // lengths near the line size and short, one channel constant high
    mode = 2;
    setLenA(60);
    runSteps(150);
    setLenB(3);
    runSteps(150);
    // run 2: capture every clock (R6 zero period), stalled consumer (R8, R9)
    mode = 0;
    doReset(0, 2, 7, 1'b0);
    runSteps(64);
    check(overflow == 1'b1, "R9", "overflow after stall", overflow, 1);
    check(byteValid == 1'b1, "R8", "valid while stalled", byteValid, 1);
    byteReady = 1'b1;
    runSteps(60);
    byteReady = 1'b0;
    runSteps(20);
    byteReady = 1'b1;
    runSteps(40);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule